// File: doc/BRIEF.md
# Deduplicating Page Map with Shared-Page Indirection

This block keeps the logical-to-physical page map for a flash translation layer that removes duplicate writes. Each logical page has an entry in a primary table. That entry is empty, holds a physical page address directly, or points into a small secondary table. A secondary entry stands for every logical page that shares one stored physical page. It carries that page's address and a count of the logical pages that refer to it. The secondary table can be much smaller than the primary table, because most logical pages hold content of their own.

The host issues one command per cycle. It can map a logical page to a newly written unique physical page. It can map a logical page onto the content already held by a source logical page. It can trim a logical page, and it can move the physical page behind a logical page to a new address. When a physical page loses its last reference, or is left behind by a move, the block reports its address on the following cycle, so that garbage collection can reclaim it. A command that cannot be carried out leaves the tables unchanged and raises a one-cycle error. A combinational query port returns the current mapping of any logical page.

Every command is applied at the clock edge where `cmdValid` is high. The invalidate and error pulses appear in the cycle after that edge. From that cycle on, the query port shows the updated tables.

Top module: `dedup_map`

## Requirements
- R1: After reset every logical page reads as unmapped (`qMapped`=0, `qShared`=0, `qPpa`=0), and `invValid` and `cmdErr` are 0. A cycle without `cmdValid` changes nothing and pulses nothing.
- R2: `cmdOp`=0 (unique) maps `cmdLpn` directly to `cmdPpa` (`qShared`=0). If `cmdLpn` held a direct mapping before, `invValid` pulses one cycle after the command with the old physical address on `invPpa`.
- R3: `cmdOp`=1 (duplicate) whose source `cmdSrcLpn` is mapped directly takes a free secondary entry with a count of 2. Both logical pages then read `qShared`=1 with the source's physical address, and no invalidation is reported for the shared page.
- R4: A duplicate whose source is already shared adds `cmdLpn` to that group and raises its count by one. All members read the same address.
- R5: Overwriting or trimming a member of a shared group lowers its count with no invalidation. When the last reference is released, `invValid` pulses with the group's physical address and the secondary entry becomes free.
- R6: `cmdOp`=2 (trim) leaves `cmdLpn` unmapped. A trim of an already unmapped page has no effect and raises neither `invValid` nor `cmdErr`.
- R7: `cmdOp`=3 (relocate) on a shared logical page rewrites only the secondary entry. Every member of the group then reads `cmdPpa`, and `invValid` pulses with the old address.
- R8: A relocate on a directly mapped logical page rewrites its primary entry to `cmdPpa`, and `invValid` pulses with the old address.
- R9: `cmdErr` pulses, with no table change and no invalidation, for a duplicate whose source is unmapped, for a relocate of an unmapped page, and for a duplicate of a direct source when no secondary entry is free.
- R10: A duplicate whose target is the source itself, or is already in the source's group, has no effect and no pulse.
- R11: A secondary entry freed by R5 can be taken again by a later duplicate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command applied at this edge |
| cmdOp | input | 2 | 0 unique, 1 duplicate, 2 trim, 3 relocate |
| cmdLpn | input | LPN_W | Target logical page |
| cmdSrcLpn | input | LPN_W | Source logical page for a duplicate |
| cmdPpa | input | PPA_W | New physical page for unique or relocate |
| qLpn | input | LPN_W | Logical page to query |
| qMapped | output | 1 | Queried page is mapped |
| qShared | output | 1 | Queried page goes through a secondary entry |
| qPpa | output | PPA_W | Physical page of the queried page (0 if unmapped) |
| invValid | output | 1 | Physical page became invalid |
| invPpa | output | PPA_W | Address of the invalidated page |
| cmdErr | output | 1 | Previous command was rejected |

## Verification
The mapping function is driven through one shared group that is first built up, then relocated, and then dissolved one member at a time. This sequence shows whether the count is tracked, because only the last release may report an invalidation, and whether a relocation reaches every member through the single shared entry. A second pattern fills the whole secondary table from direct sources. It separates correct exhaustion handling, where the error leaves the source intact, from silent corruption, and then shows that a released entry is taken again. Trims of unmapped pages, duplicates within one group, and commands on unmapped sources check that no-op cases produce no pulse and no change.

// File: rtl/dedup_map_pkg.sv
package dedup_map_pkg;

  typedef enum logic [1:0] {
    OP_UNIQUE = 2'd0,
    OP_DUP    = 2'd1,
    OP_TRIM   = 2'd2,
    OP_RELOC  = 2'd3
  } mapOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic priAWr;     // write primary entry of target page
    logic priAValid;
    logic priAVba;
    logic priSWr;     // write primary entry of source page (to new group)
    logic secAlloc;   // take a free secondary entry, count 2
    logic secInc;
    logic secDec;
    logic secSetPpa;  // move shared page
    logic invFire;
    logic errFire;
  } mapStrobe_t;

endpackage

// File: rtl/dedup_map_ctrl.sv
module dedup_map_ctrl
  import dedup_map_pkg::*;
#(
  parameter int LPN_W = 4,
  parameter int VBA_W = 2,
  parameter int PPA_W = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [LPN_W-1:0] cmdLpn,
  input  logic [LPN_W-1:0] cmdSrcLpn,
  input  logic [PPA_W-1:0] cmdPpa,
  input  logic             entAValid,
  input  logic             entAVba,
  input  logic [PPA_W-1:0] entAPtr,
  input  logic             entSValid,
  input  logic             entSVba,
  input  logic [PPA_W-1:0] entSPtr,
  input  logic [CNT_W-1:0] secACnt,
  input  logic [PPA_W-1:0] secAPpa,
  input  logic             freeAvail,
  input  logic [VBA_W-1:0] freeIdx,
  output mapStrobe_t       st,
  output logic [PPA_W-1:0] priPtrNext,
  output logic [VBA_W-1:0] allocIdx,
  output logic [PPA_W-1:0] allocPpa,
  output logic [VBA_W-1:0] incIdx,
  output logic [VBA_W-1:0] decIdx,
  output logic [VBA_W-1:0] setIdx,
  output logic [PPA_W-1:0] invPpaNext
);

  mapOp_e op;
  logic   relInv, relDec, sameGrp;

  assign op         = mapOp_e'(cmdOp);
  assign allocIdx   = freeIdx;
  assign allocPpa   = entSPtr;
  assign incIdx     = entSPtr[VBA_W-1:0];
  assign decIdx     = entAPtr[VBA_W-1:0];
  assign setIdx     = entAPtr[VBA_W-1:0];
  assign invPpaNext = entAVba ? secAPpa : entAPtr;

  // releasing the target's old mapping
  assign relDec  = entAValid && entAVba;
  assign relInv  = entAValid && (!entAVba || secACnt == CNT_W'(1));
  assign sameGrp = (cmdLpn == cmdSrcLpn) ||
                   (entAValid && entAVba && entSValid && entSVba &&
                    entAPtr[VBA_W-1:0] == entSPtr[VBA_W-1:0]);

  always_comb begin
    st         = '0;
    priPtrNext = cmdPpa;
    if (cmdValid) begin
      unique case (op)
        OP_UNIQUE: begin
          st.priAWr    = 1'b1;
          st.priAValid = 1'b1;
          st.secDec    = relDec;
          st.invFire   = relInv;
        end
        OP_TRIM: begin
          st.priAWr  = entAValid;
          st.secDec  = relDec;
          st.invFire = relInv;
        end
        OP_DUP: begin
          if (!entSValid) begin
            st.errFire = 1'b1;
          end else if (sameGrp) begin
            st = '0;
          end else if (entSVba) begin
            st.secInc    = 1'b1;
            st.secDec    = relDec;
            st.invFire   = relInv;
            st.priAWr    = 1'b1;
            st.priAValid = 1'b1;
            st.priAVba   = 1'b1;
            priPtrNext   = entSPtr;
          end else if (!freeAvail) begin
            st.errFire = 1'b1;
          end else begin
            st.secAlloc  = 1'b1;
            st.secDec    = relDec;
            st.invFire   = relInv;
            st.priAWr    = 1'b1;
            st.priAValid = 1'b1;
            st.priAVba   = 1'b1;
            st.priSWr    = 1'b1;
            priPtrNext   = PPA_W'(freeIdx);
          end
        end
        OP_RELOC: begin
          if (!entAValid) begin
            st.errFire = 1'b1;
          end else if (entAVba) begin
            st.secSetPpa = 1'b1;
            st.invFire   = 1'b1;
          end else begin
            st.priAWr    = 1'b1;
            st.priAValid = 1'b1;
            st.invFire   = 1'b1;
          end
        end
        default: st = '0;
      endcase
    end
  end

  // a shared page move must touch only the secondary entry
  AST_RELOC_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && op == OP_RELOC && entAValid && entAVba) |-> (!st.priAWr && !st.priSWr && st.secSetPpa)); // R7

  // a rejected command touches nothing
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    st.errFire |-> !(st.priAWr || st.priSWr || st.secAlloc || st.secInc || st.secDec || st.secSetPpa || st.invFire)); // R9

endmodule

// File: rtl/dedup_map_dp.sv
module dedup_map_dp
  import dedup_map_pkg::*;
#(
  parameter int NUM_LPN = 16,
  parameter int NUM_VBA = 4,
  parameter int LPN_W   = 4,
  parameter int VBA_W   = 2,
  parameter int PPA_W   = 8,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LPN_W-1:0] cmdLpn,
  input  logic [LPN_W-1:0] cmdSrcLpn,
  input  logic [LPN_W-1:0] qLpn,
  input  mapStrobe_t       st,
  input  logic [PPA_W-1:0] priPtrNext,
  input  logic [VBA_W-1:0] allocIdx,
  input  logic [PPA_W-1:0] allocPpa,
  input  logic [VBA_W-1:0] incIdx,
  input  logic [VBA_W-1:0] decIdx,
  input  logic [VBA_W-1:0] setIdx,
  input  logic [PPA_W-1:0] setPpa,
  input  logic [PPA_W-1:0] invPpaNext,
  output logic             entAValid,
  output logic             entAVba,
  output logic [PPA_W-1:0] entAPtr,
  output logic             entSValid,
  output logic             entSVba,
  output logic [PPA_W-1:0] entSPtr,
  output logic [CNT_W-1:0] secACnt,
  output logic [PPA_W-1:0] secAPpa,
  output logic             freeAvail,
  output logic [VBA_W-1:0] freeIdx,
  output logic             qMapped,
  output logic             qShared,
  output logic [PPA_W-1:0] qPpa,
  output logic             invValid,
  output logic [PPA_W-1:0] invPpa,
  output logic             cmdErr
);

  logic             priValid [NUM_LPN];
  logic             priVba   [NUM_LPN];
  logic [PPA_W-1:0] priPtr   [NUM_LPN];
  logic [PPA_W-1:0] secPpa   [NUM_VBA];
  logic [CNT_W-1:0] secCnt   [NUM_VBA];

  // lookups
  assign entAValid = priValid[cmdLpn];
  assign entAVba   = priVba[cmdLpn];
  assign entAPtr   = priPtr[cmdLpn];
  assign entSValid = priValid[cmdSrcLpn];
  assign entSVba   = priVba[cmdSrcLpn];
  assign entSPtr   = priPtr[cmdSrcLpn];
  assign secACnt   = secCnt[entAPtr[VBA_W-1:0]];
  assign secAPpa   = secPpa[entAPtr[VBA_W-1:0]];

  assign qMapped = priValid[qLpn];
  assign qShared = priValid[qLpn] && priVba[qLpn];
  assign qPpa    = !priValid[qLpn] ? '0 :
                   priVba[qLpn] ? secPpa[priPtr[qLpn][VBA_W-1:0]] : priPtr[qLpn];

  // free list: lowest free secondary entry
  always_comb begin
    freeAvail = 1'b0;
    freeIdx   = '0;
    for (int i = NUM_VBA - 1; i >= 0; i--) begin
      if (secCnt[i] == '0) begin
        freeAvail = 1'b1;
        freeIdx   = VBA_W'(i);
      end
    end
  end

  // primary table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LPN; i++) begin
        priValid[i] <= 1'b0;
        priVba[i]   <= 1'b0;
        priPtr[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_LPN; i++) begin
        if (st.priAWr && cmdLpn == LPN_W'(i)) begin
          priValid[i] <= st.priAValid;
          priVba[i]   <= st.priAVba;
          priPtr[i]   <= st.priAValid ? priPtrNext : '0;
        end else if (st.priSWr && cmdSrcLpn == LPN_W'(i)) begin
          priValid[i] <= 1'b1;
          priVba[i]   <= 1'b1;
          priPtr[i]   <= priPtrNext;
        end
      end
    end
  end

  // secondary table
  for (genvar v = 0; v < NUM_VBA; v++) begin : gSec
    always_ff @(posedge clk) begin
      if (!rstN) begin
        secCnt[v] <= '0;
        secPpa[v] <= '0;
      end else if (st.secAlloc && allocIdx == VBA_W'(v)) begin
        secCnt[v] <= CNT_W'(2);
        secPpa[v] <= allocPpa;
      end else begin
        if (st.secSetPpa && setIdx == VBA_W'(v)) secPpa[v] <= setPpa;
        if (st.secInc && incIdx == VBA_W'(v))      secCnt[v] <= secCnt[v] + CNT_W'(1);
        else if (st.secDec && decIdx == VBA_W'(v)) secCnt[v] <= secCnt[v] - CNT_W'(1);
      end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      secCnt[v] <= CNT_W'(NUM_LPN)); // R4
  end

  // event pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      invValid <= 1'b0;
      invPpa   <= '0;
      cmdErr   <= 1'b0;
    end else begin
      invValid <= st.invFire;
      invPpa   <= st.invFire ? invPpaNext : '0;
      cmdErr   <= st.errFire;
    end
  end

  AST_ALLOC_FREE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    st.secAlloc |-> (secCnt[allocIdx] == '0)); // R3

  AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    st.secDec |-> (secCnt[decIdx] != '0)); // R5

  AST_ERR_NO_INV: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |-> !invValid); // R9

  for (genvar p = 0; p < NUM_LPN; p++) begin : gLink
    AST_SHARED_LIVE: assert property (@(posedge clk) disable iff (!rstN)
      (priValid[p] && priVba[p]) |-> (secCnt[priPtr[p][VBA_W-1:0]] != '0)); // R5
  end

endmodule

// File: rtl/dedup_map.sv
module dedup_map
  import dedup_map_pkg::*;
#(
  parameter int NUM_LPN = 16,
  parameter int NUM_VBA = 4,
  parameter int PPA_W   = 8,
  localparam int LPN_W  = $clog2(NUM_LPN),
  localparam int VBA_W  = $clog2(NUM_VBA),
  localparam int CNT_W  = $clog2(NUM_LPN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [LPN_W-1:0] cmdLpn,
  input  logic [LPN_W-1:0] cmdSrcLpn,
  input  logic [PPA_W-1:0] cmdPpa,
  input  logic [LPN_W-1:0] qLpn,
  output logic             qMapped,
  output logic             qShared,
  output logic [PPA_W-1:0] qPpa,
  output logic             invValid,
  output logic [PPA_W-1:0] invPpa,
  output logic             cmdErr
);

  mapStrobe_t       st;
  logic             entAValid, entAVba, entSValid, entSVba, freeAvail;
  logic [PPA_W-1:0] entAPtr, entSPtr, secAPpa, priPtrNext, allocPpa, invPpaNext;
  logic [CNT_W-1:0] secACnt;
  logic [VBA_W-1:0] freeIdx, allocIdx, incIdx, decIdx, setIdx;

  dedup_map_ctrl #(.LPN_W(LPN_W), .VBA_W(VBA_W), .PPA_W(PPA_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLpn(cmdLpn),
    .cmdSrcLpn(cmdSrcLpn), .cmdPpa(cmdPpa),
    .entAValid(entAValid), .entAVba(entAVba), .entAPtr(entAPtr),
    .entSValid(entSValid), .entSVba(entSVba), .entSPtr(entSPtr),
    .secACnt(secACnt), .secAPpa(secAPpa), .freeAvail(freeAvail), .freeIdx(freeIdx),
    .st(st), .priPtrNext(priPtrNext), .allocIdx(allocIdx), .allocPpa(allocPpa),
    .incIdx(incIdx), .decIdx(decIdx), .setIdx(setIdx), .invPpaNext(invPpaNext)
  );

  dedup_map_dp #(.NUM_LPN(NUM_LPN), .NUM_VBA(NUM_VBA), .LPN_W(LPN_W), .VBA_W(VBA_W),
                 .PPA_W(PPA_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cmdLpn(cmdLpn), .cmdSrcLpn(cmdSrcLpn), .qLpn(qLpn),
    .st(st), .priPtrNext(priPtrNext), .allocIdx(allocIdx), .allocPpa(allocPpa),
    .incIdx(incIdx), .decIdx(decIdx), .setIdx(setIdx), .setPpa(cmdPpa),
    .invPpaNext(invPpaNext),
    .entAValid(entAValid), .entAVba(entAVba), .entAPtr(entAPtr),
    .entSValid(entSValid), .entSVba(entSVba), .entSPtr(entSPtr),
    .secACnt(secACnt), .secAPpa(secAPpa), .freeAvail(freeAvail), .freeIdx(freeIdx),
    .qMapped(qMapped), .qShared(qShared), .qPpa(qPpa),
    .invValid(invValid), .invPpa(invPpa), .cmdErr(cmdErr)
  );

endmodule

// File: tb/sim_dedup_map.sv
module sim_dedup_map;

  localparam int NUM_LPN = 16;
  localparam int PPA_W   = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [3:0] cmdLpn = '0, cmdSrcLpn = '0, qLpn = '0;
  logic [7:0] cmdPpa = '0;
  logic       qMapped, qShared, invValid, cmdErr;
  logic [7:0] qPpa, invPpa;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  dedup_map #(.NUM_LPN(NUM_LPN), .NUM_VBA(4), .PPA_W(PPA_W)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLpn(cmdLpn),
    .cmdSrcLpn(cmdSrcLpn), .cmdPpa(cmdPpa), .qLpn(qLpn), .qMapped(qMapped),
    .qShared(qShared), .qPpa(qPpa), .invValid(invValid), .invPpa(invPpa), .cmdErr(cmdErr)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [3:0] lpn;
    logic [3:0] src;
    logic [7:0] ppa;
    logic       eInv;
    logic [7:0] eInvPpa;
    logic       eErr;
    logic [3:0] qL;
    logic       eMap;
    logic       eSh;
    logic [7:0] ePpa;
    logic [7:0] req;
  } vec_t;

  function automatic vec_t mk(int op, int lpn, int src, int ppa, int eInv, int eInvPpa,
                              int eErr, int qL, int eMap, int eSh, int ePpa, int req);
    vec_t v;
    v = '{op[1:0], lpn[3:0], src[3:0], ppa[7:0], eInv[0], eInvPpa[7:0], eErr[0],
          qL[3:0], eMap[0], eSh[0], ePpa[7:0], req[7:0]};
    return v;
  endfunction

  // op: 0 unique, 1 duplicate, 2 trim, 3 relocate
  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    mk(0, 1, 0, 'h10, 0, 0,    0, 1, 1, 0, 'h10, 2),   // R2 first map
    mk(0, 1, 0, 'h11, 1, 'h10, 0, 1, 1, 0, 'h11, 2),   // R2 overwrite direct
    mk(1, 2, 1, 0,    0, 0,    0, 2, 1, 1, 'h11, 3),   // R3 new group
    mk(1, 3, 2, 0,    0, 0,    0, 1, 1, 1, 'h11, 4),   // R4 join group
    mk(3, 2, 0, 'h30, 1, 'h11, 0, 3, 1, 1, 'h30, 7),   // R7 move shared page
    mk(2, 2, 0, 0,    0, 0,    0, 2, 0, 0, 0,    5),   // R5 count 3->2
    mk(0, 3, 0, 'h20, 0, 0,    0, 1, 1, 1, 'h30, 5),   // R5 count 2->1
    mk(2, 1, 0, 0,    1, 'h30, 0, 1, 0, 0, 0,    5),   // R5 last release
    mk(3, 3, 0, 'h21, 1, 'h20, 0, 3, 1, 0, 'h21, 8),   // R8 move unique page
    mk(2, 5, 0, 0,    0, 0,    0, 5, 0, 0, 0,    6),   // R6 trim unmapped
    mk(1, 6, 5, 0,    0, 0,    1, 6, 0, 0, 0,    9),   // R9 unmapped source
    mk(3, 7, 0, 'h33, 0, 0,    1, 7, 0, 0, 0,    9),   // R9 relocate unmapped
    mk(1, 3, 3, 0,    0, 0,    0, 3, 1, 0, 'h21, 10),  // R10 self duplicate
    mk(0, 8,  0, 'h48, 0, 0,   0, 8,  1, 0, 'h48, 2),  // R2
    mk(0, 9,  0, 'h49, 0, 0,   0, 9,  1, 0, 'h49, 2),  // R2
    mk(0, 10, 0, 'h4A, 0, 0,   0, 10, 1, 0, 'h4A, 2),  // R2
    mk(0, 11, 0, 'h4B, 0, 0,   0, 11, 1, 0, 'h4B, 2),  // R2
    mk(0, 12, 0, 'h4C, 0, 0,   0, 12, 1, 0, 'h4C, 2),  // R2
    mk(0, 13, 0, 'h4D, 0, 0,   0, 13, 1, 0, 'h4D, 2),  // R2
    mk(0, 14, 0, 'h4E, 0, 0,   0, 14, 1, 0, 'h4E, 2),  // R2
    mk(0, 15, 0, 'h4F, 0, 0,   0, 15, 1, 0, 'h4F, 2),  // R2
    mk(1, 9,  8,  0, 1, 'h49, 0, 8,  1, 1, 'h48, 3),   // R3 target old page dropped
    mk(1, 11, 10, 0, 1, 'h4B, 0, 11, 1, 1, 'h4A, 3),   // R3
    mk(1, 13, 12, 0, 1, 'h4D, 0, 13, 1, 1, 'h4C, 3),   // R3
    mk(1, 15, 14, 0, 1, 'h4F, 0, 15, 1, 1, 'h4E, 3),   // R3 table now full
    mk(1, 1, 3, 0,    0, 0,    1, 3, 1, 0, 'h21, 9),   // R9 no free entry
    mk(1, 10, 11, 0,  0, 0,    0, 10, 1, 1, 'h4A, 10), // R10 same group
    mk(2, 9, 0, 0,    0, 0,    0, 8, 1, 1, 'h48, 5),   // R5 count 2->1
    mk(2, 8, 0, 0,    1, 'h48, 0, 8, 0, 0, 0,    5),   // R5 entry freed
    mk(1, 1, 3, 0,    0, 0,    0, 1, 1, 1, 'h21, 11),  // R11 reuse
    mk(1, 4, 13, 0,   0, 0,    0, 12, 1, 1, 'h4C, 4)   // R4
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, still in reset
    for (int i = 0; i < NUM_LPN; i++) begin
      qLpn = 4'(i);
      #0.1;
      chk(!qMapped && !qShared && qPpa == 0, "R1", "reset map", {qMapped, qShared, qPpa}, 0);
    end
    chk(!invValid && !cmdErr, "R1", "reset pulses", {invValid, cmdErr}, 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      cmdValid  = 1'b1;
      cmdOp     = VECS[k].op;
      cmdLpn    = VECS[k].lpn;
      cmdSrcLpn = VECS[k].src;
      cmdPpa    = VECS[k].ppa;
      qLpn      = VECS[k].qL;
      @(posedge clk);
      @(negedge clk);
      cmdValid = 1'b0;
      chk(invValid == VECS[k].eInv && cmdErr == VECS[k].eErr &&
          (!VECS[k].eInv || invPpa == VECS[k].eInvPpa),
          $sformatf("R%0d", VECS[k].req), $sformatf("pulses step %0d", k),
          {invValid, cmdErr, invPpa}, {VECS[k].eInv, VECS[k].eErr, VECS[k].eInvPpa});
      chk(qMapped == VECS[k].eMap && qShared == VECS[k].eSh && qPpa == VECS[k].ePpa,
          $sformatf("R%0d", VECS[k].req), $sformatf("map step %0d", k),
          {qMapped, qShared, qPpa}, {VECS[k].eMap, VECS[k].eSh, VECS[k].ePpa});
    end

    // R1 idle cycle: command inputs present but not valid
    cmdOp = 2'd2; cmdLpn = 4'd1; qLpn = 4'd1;
    @(posedge clk);
    @(negedge clk);
    chk(!invValid && !cmdErr && qMapped && qPpa == 8'h21, "R1", "idle no change",
        {invValid, cmdErr, qPpa}, 8'h21);

    // R7 the other shared member follows the group
    qLpn = 4'd3;
    #0.1;
    chk(qShared && qPpa == 8'h21, "R7", "group member", {qShared, qPpa}, {1'b1, 8'h21});

    // R1 reset clears the tables
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    qLpn = 4'd12;
    #0.1;
    chk(!qMapped && !qShared && qPpa == 0 && !invValid, "R1", "after reset",
        {qMapped, qShared, qPpa}, 0);

    done = 1'b1;
    finishRun();
  end

endmodule